// File: doc/BRIEF.md
# SDRAM Burst Sequencer with Row Crossing

This block turns one accepted memory request into the command stream an SDRAM needs: a row activate, a run of column read or write commands with a data strobe per 16-bit bus transfer, and a closing precharge. It takes requests from two sources. A display-refresh port always fetches a fixed 8-transfer, 16-bit read. A general port, used by cache refill and DMA, picks one of four burst shapes and a direction.

The sequencer keeps the running word address in one register and steps it with a local incrementer on every column command. When a burst reaches the last column of the open row with transfers still left, it closes that row and opens the next one. It then waits out the activate-to-column delay and carries on from column 0. This lets a burst start at any word address. When both ports request in the same idle cycle, the display port wins. A one-cycle done pulse, issued together with the final precharge, marks the end of each burst.

Top module: `sdram_burst_seq`

## Requirements
- R1: General shape code `gen_shape` sets the number of column commands: 0 = one 8-bit beat (1 transfer), 1 = one 16-bit beat (1 transfer), 2 = one 32-bit beat (2 transfers), 3 = four 32-bit beats (8 transfers).
- R2: A display request always produces 8 read transfers on 16-bit lanes, whatever `gen_shape` and `gen_we` hold.
- R3: No burst issues more than 8 column commands.
- R4: When `disp_req` and `gen_req` are both high in an idle cycle, only `disp_ack` is given; the general request is taken after the display burst ends.
- R5: A burst starts with ACT (`cmd`=1) carrying the row (address bits above the column field) on `sd_addr`. The first column command follows T_RCD cycles later, with NOP (`cmd`=0) in between.
- R6: If a column command addresses the last column of a row and transfers remain, the sequencer issues PRE (`cmd`=4), waits T_RP cycles in total, issues ACT for the next row, waits T_RCD, and resumes at column 0.
- R7: A 32-bit beat is sent as two consecutive transfers. The low half comes first (`hi_half`=0), then the high half (`hi_half`=1).
- R8: `lane_en` is 2'b01 for the 8-bit shape, 2'b11 for every other column command, and 2'b00 outside column commands.
- R9: `done` is high for exactly one cycle, the cycle right after the last strobed transfer, together with a closing PRE.
- R10: During and right after reset, `cmd` is NOP and `dstb`, `done` and `lane_en` are low. An ack is given only while idle, and at most one at a time.
- R11: A general request issues READ (`cmd`=2) when `gen_we`=0 and WRITE (`cmd`=3) when `gen_we`=1. During a column command, `sd_addr` carries the column, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_req | input | 1 | Display fetch request, held until acked |
| disp_addr | input | ROW_W+COL_W | Display start word address |
| gen_req | input | 1 | General request, held until acked |
| gen_addr | input | ROW_W+COL_W | General start word address |
| gen_shape | input | 2 | General burst shape code |
| gen_we | input | 1 | General direction, 1 = write |
| disp_ack | output | 1 | Display request accepted this cycle |
| gen_ack | output | 1 | General request accepted this cycle |
| cmd | output | 3 | SDRAM command: 0 NOP, 1 ACT, 2 READ, 3 WRITE, 4 PRE |
| sd_addr | output | ROW_W | Row on ACT, column on READ/WRITE |
| dstb | output | 1 | One 16-bit data transfer this cycle |
| hi_half | output | 1 | Transfer carries the upper half of a 32-bit beat |
| lane_en | output | 2 | Active byte lanes of the transfer |
| done | output | 1 | Burst finished pulse |

## Verification
The checker watches every cycle for these rules: the cap of 8 column commands per burst, the single-cycle done that follows a strobe, the NOP gap after every ACT, the absence of strobes on PRE, mutually exclusive acks, and the display port's precedence. The exact command traces can only be shown by the bench scenarios. These are the transfer count of each shape, the row-crossing PRE/ACT sequence with the column restarting at 0, the low-then-high ordering of 32-bit halves, the address wrap at the top row, and a burst that ends exactly on the last column without crossing.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  localparam int AW   = ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_req,
  input  logic [AW-1:0]    disp_addr,
  input  logic             gen_req,
  input  logic [AW-1:0]    gen_addr,
  input  logic [1:0]       gen_shape,
  input  logic             gen_we,
  output logic             disp_ack,
  output logic             gen_ack,
  output logic [2:0]       cmd,
  output logic [ROW_W-1:0] sd_addr,
  output logic             dstb,
  output logic             hi_half,
  output logic [1:0]       lane_en,
  output logic             done
);
  localparam int WT_W = 4;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_RCD, S_COL, S_XPRE, S_RP, S_END} st_t;

  st_t             st;
  logic [AW-1:0]   cur;
  logic [3:0]      left;
  logic [WT_W-1:0] wt;
  logic            we_q, b8_q, w32_q, odd_q;
  logic [3:0]      gen_beats;
  logic            col_end;

  assign disp_ack = (st == S_IDLE) && disp_req;
  assign gen_ack  = (st == S_IDLE) && gen_req && !disp_req;
  assign col_end  = &cur[COL_W-1:0];

  always_comb begin
    case (gen_shape)
      2'd2:    gen_beats = 4'd2;
      2'd3:    gen_beats = 4'd8;
      default: gen_beats = 4'd1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; left <= '0; wt <= '0;
      we_q <= 1'b0; b8_q <= 1'b0; w32_q <= 1'b0; odd_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          odd_q <= 1'b0;
          if (disp_ack) begin
            st <= S_ACT; cur <= disp_addr; left <= 4'd8;
            we_q <= 1'b0; b8_q <= 1'b0; w32_q <= 1'b0;
          end else if (gen_ack) begin
            st <= S_ACT; cur <= gen_addr; left <= gen_beats;
            we_q <= gen_we; b8_q <= (gen_shape == 2'd0); w32_q <= gen_shape[1];
          end
        end
        S_ACT: begin
          st <= S_RCD; wt <= WT_W'(T_RCD - 2);
        end
        S_RCD: begin
          if (wt == '0) st <= S_COL;
          else wt <= wt - 1'b1;
        end
        S_COL: begin
          cur   <= cur + 1'b1;
          left  <= left - 1'b1;
          odd_q <= ~odd_q;
          if (left == 4'd1) st <= S_END;
          else if (col_end) st <= S_XPRE;
        end
        S_XPRE: begin
          st <= S_RP; wt <= WT_W'(T_RP - 2);
        end
        S_RP: begin
          if (wt == '0) st <= S_ACT;
          else wt <= wt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_ACT:         cmd = C_ACT;
      S_COL:         cmd = we_q ? C_WR : C_RD;
      S_XPRE, S_END: cmd = C_PRE;
      default:       cmd = C_NOP;
    endcase
  end

  assign sd_addr = (st == S_ACT) ? cur[AW-1:COL_W] :
                   (st == S_COL) ? ROW_W'(cur[COL_W-1:0]) : '0;
  assign dstb    = (st == S_COL);
  assign hi_half = dstb && w32_q && odd_q;
  assign lane_en = dstb ? (b8_q ? 2'b01 : 2'b11) : 2'b00;
  assign done    = (st == S_END);
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       disp_req,
  input logic       gen_req,
  input logic       disp_ack,
  input logic       gen_ack,
  input logic [2:0] cmd,
  input logic       dstb,
  input logic       hi_half,
  input logic       done
);
  logic [4:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || done) bcnt <= '0;
    else if (dstb) bcnt <= bcnt + 1'b1;
  end

  p_burst_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dstb |-> bcnt < 5'd8);
  p_done_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(dstb));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd == 3'd4);
  p_act_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd1 |=> cmd == 3'd0);
  p_pre_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'd4 |-> !dstb);
  p_one_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({disp_ack, gen_ack}));
  p_disp_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_req && gen_req) |-> !gen_ack);
  p_half_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dstb && hi_half) |=> !(dstb && hi_half));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .gen_req(gen_req),
  .disp_ack(disp_ack), .gen_ack(gen_ack), .cmd(cmd), .dstb(dstb),
  .hi_half(hi_half), .done(done)
);

// File: tb/sdram_burst_seq_bench.sv
module sdram_burst_seq_bench;
  localparam int ROW_W = 12, COL_W = 8, T_RCD = 2, T_RP = 2;
  localparam int AW = ROW_W + COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_req = 1'b0, gen_req = 1'b0, gen_we = 1'b0;
  logic [AW-1:0] disp_addr = '0, gen_addr = '0;
  logic [1:0] gen_shape = '0;
  logic disp_ack, gen_ack, dstb, hi_half, done;
  logic [2:0] cmd;
  logic [ROW_W-1:0] sd_addr;
  logic [1:0] lane_en;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  sdram_burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP)) u_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .disp_addr(disp_addr),
    .gen_req(gen_req), .gen_addr(gen_addr), .gen_shape(gen_shape), .gen_we(gen_we),
    .disp_ack(disp_ack), .gen_ack(gen_ack), .cmd(cmd), .sd_addr(sd_addr),
    .dstb(dstb), .hi_half(hi_half), .lane_en(lane_en), .done(done));

  typedef struct packed {
    logic disp; logic [1:0] shape; logic we; logic [AW-1:0] addr;
    logic [3:0] beats; logic [4:0] cycles;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 2'd0, 1'b0, 20'h00310, 4'd1, 5'd4},
    '{1'b0, 2'd1, 1'b1, 20'h00420, 4'd1, 5'd4},
    '{1'b0, 2'd2, 1'b0, 20'h00505, 4'd2, 5'd5},
    '{1'b0, 2'd3, 1'b1, 20'h00610, 4'd8, 5'd11},
    '{1'b1, 2'd0, 1'b0, 20'h00700, 4'd8, 5'd11},
    '{1'b0, 2'd3, 1'b0, 20'h008FC, 4'd8, 5'd15},
    '{1'b1, 2'd0, 1'b0, 20'h009FF, 4'd8, 5'd15},
    '{1'b0, 2'd2, 1'b1, 20'h00AFF, 4'd2, 5'd9},
    '{1'b0, 2'd3, 1'b0, 20'h00BF8, 4'd8, 5'd11},
    '{1'b1, 2'd0, 1'b1, 20'h00C00, 4'd8, 5'd11},
    '{1'b0, 2'd3, 1'b0, 20'hFFFFE, 4'd8, 5'd15}
  };

  typedef struct packed {
    logic [2:0] c; logic [ROW_W-1:0] a; logic s; logic h; logic [1:0] l; logic d;
  } ent_t;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string req);
    ent_t exp_t [48];
    ent_t got;
    int ne = 0, n = 0, beats = 0, nbeat;
    logic [AW-1:0] a;
    logic wr;
    bit w32, b8, mism = 0;
    nbeat = v.disp ? 8 : (v.shape == 2'd3 ? 8 : (v.shape == 2'd2 ? 2 : 1));
    wr  = v.disp ? 1'b0 : v.we;
    w32 = !v.disp && v.shape[1];
    b8  = !v.disp && v.shape == 2'd0;
    a = v.addr;
    exp_t[ne++] = '{3'd1, a[AW-1:COL_W], 1'b0, 1'b0, 2'b00, 1'b0};
    for (int i = 0; i < T_RCD - 1; i++) exp_t[ne++] = '0;
    for (int k = 0; k < nbeat; k++) begin
      if (k > 0 && a[COL_W-1:0] == '0) begin
        exp_t[ne++] = '{3'd4, '0, 1'b0, 1'b0, 2'b00, 1'b0};
        for (int i = 0; i < T_RP - 1; i++) exp_t[ne++] = '0;
        exp_t[ne++] = '{3'd1, a[AW-1:COL_W], 1'b0, 1'b0, 2'b00, 1'b0};
        for (int i = 0; i < T_RCD - 1; i++) exp_t[ne++] = '0;
      end
      exp_t[ne++] = '{wr ? 3'd3 : 3'd2, ROW_W'(a[COL_W-1:0]), 1'b1,
                      w32 && k[0], b8 ? 2'b01 : 2'b11, 1'b0};
      a = a + 1'b1;
    end
    exp_t[ne++] = '{3'd4, '0, 1'b0, 1'b0, 2'b00, 1'b1};

    @(negedge clk);
    disp_req = v.disp; disp_addr = v.addr;
    gen_req = !v.disp; gen_addr = v.addr; gen_shape = v.shape; gen_we = v.we;
    #1;
    check(v.disp ? disp_ack : gen_ack, "R10", "ack while idle", 0, 1);
    @(negedge clk);
    disp_req = 1'b0; gen_req = 1'b0;
    while (n < 40) begin
      got = '{cmd, sd_addr, dstb, hi_half, lane_en, done};
      if (n < ne && got != exp_t[n]) begin
        if (!mism) $display("FAIL %s trace cycle %0d: actual %0h expected %0h", req, n, got, exp_t[n]);
        mism = 1;
      end
      if (dstb) beats++;
      n++;
      if (done) break;
      @(negedge clk);
    end
    tests++;
    if (mism) fails++;
    check(beats == int'(v.beats), req, "strobe count", beats, int'(v.beats));
    check(n == int'(v.cycles) && n == ne, req, "burst length", n, int'(v.cycles));
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <100000", wd);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
      end
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check(cmd == 3'd0 && !dstb && !done && lane_en == 2'b00, "R10", "state in reset", cmd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd == 3'd0 && !dstb && !done, "R10", "state after reset", cmd, 0);

    for (int i = 0; i < 11; i++) begin
      case (i)
        0, 1:    run_vec(VEC[i], "R1 R8 R11");
        2, 3:    run_vec(VEC[i], "R1 R7 R5");
        4, 9:    run_vec(VEC[i], "R2");
        8:       run_vec(VEC[i], "R9 R3 no-cross");
        default: run_vec(VEC[i], "R6 R7");
      endcase
    end

    // R4: simultaneous requests
    @(negedge clk);
    disp_req = 1'b1; disp_addr = 20'h00D00;
    gen_req = 1'b1; gen_addr = 20'h00E00; gen_shape = 2'd1; gen_we = 1'b1;
    #1;
    check(disp_ack && !gen_ack, "R4", "display wins", {disp_ack, gen_ack}, 2'b10);
    @(negedge clk);
    disp_req = 1'b0;
    k = 0;
    while (!done && k < 40) begin @(negedge clk); k++; end
    check(!gen_ack, "R4", "general held during burst end", gen_ack, 0);
    @(negedge clk);
    #1;
    check(gen_ack, "R4", "general taken after display", gen_ack, 1);
    @(negedge clk);
    gen_req = 1'b0;
    repeat (2) @(negedge clk);
    check(cmd == 3'd3 && sd_addr == '0 && dstb, "R4 R11", "general write issued", cmd, 3);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule